// File: doc/BRIEF.md
# Dual-Slope Phase-Correct PWM Generator

This block drives two pulse-width-modulated pins from a single 8-bit counter that climbs from zero to a turning value and then descends back to zero, over and over. Each pin changes level when the counter crosses its compare value. It is cleared at the crossing on the rising slope and set at the crossing on the falling slope. The pulses are therefore centred on the bottom of the count, and their centres stay fixed as the duty cycle changes. This suits motor drives and other loads that are sensitive to phase.

The turning value is either the full-scale count or the value buffered from compare channel A, chosen by a three-bit waveform-mode field. The counter moves only on clocks where the external prescaler enable is high. Compare values are double buffered, so a new duty cycle never splits a period unevenly. Each pin has a two-bit output-mode field that selects off, normal polarity or inverted polarity. The current count and its direction are also available as outputs.

Top module: `pc_pwm`

## Requirements
- R1: `wave_mode` 3'd1 selects a turning value of 255, and 3'd5 selects the buffered channel-A compare value. Any other code freezes `count` and `dir_down` and makes both compare buffers copy their inputs on every clock.
- R2: On a clock with `tick` low, `count` and `dir_down` keep their values.
- R3: While rising (`dir_down`=0), each tick adds one to `count`. A tick taken at or above the turning value steps `count` down by one and raises `dir_down`, so the turning value is shown for exactly one tick.
- R4: A tick taken at zero while falling sets `count` to 1 and clears `dir_down`, so one full period lasts twice the turning value in ticks.
- R5: `dir_down` is 1 exactly when the present `count` was reached by a downward step. Reset clears `count`, `dir_down`, both pins and both compare buffers.
- R6: The compare inputs are copied into their working buffers only on the tick that leaves the turning value, or on any clock while the counter is frozen. Changing the inputs at any other time leaves the current period unchanged.
- R7: Output-mode code 2'b10 gives normal polarity and 2'b11 gives inverted polarity. Codes 2'b00 and 2'b01 hold the pin at 0. A new code takes effect on the next clock.
- R8: In normal polarity, with a buffered compare value c strictly between 0 and the turning value, the pin is high while rising if count < c and while falling if count <= c. This gives 2·c high ticks per period.
- R9: A buffered compare value of 0 keeps the pin at its inactive level (low in normal polarity). A value at or above the turning value keeps it at its active level (high in normal polarity). The zero case is checked first.
- R10: Inverted polarity gives the exact complement of the normal-polarity pin.
- R11: The pins are registered on the same edge as `count`, so each pin level matches the `count`, `dir_down` and buffers shown in the same cycle.
- R12: A turning value of 0 (mode 3'd5 with buffered channel A at 0) holds `count` at 0 with `dir_down` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Prescaler enable; counter steps only when high |
| wave_mode | input | 3 | Waveform mode (1: turn at 255, 5: turn at channel A) |
| cmp_a | input | 8 | Channel A compare value (also turning value in mode 5) |
| cmp_b | input | 8 | Channel B compare value |
| out_mode_a | input | 2 | Channel A pin mode (0x off, 10 normal, 11 inverted) |
| out_mode_b | input | 2 | Channel B pin mode (0x off, 10 normal, 11 inverted) |
| count | output | 8 | Current counter value |
| dir_down | output | 1 | High when the current count was reached counting down |
| pwm_a | output | 1 | Channel A PWM pin |
| pwm_b | output | 1 | Channel B PWM pin |

## Verification
A direction bit that is wrong after a turn shows up on the next tick. It appears as a second sample at the turning value or at zero, or as a period other than twice the turning value. A compare buffer that loads at the wrong time shows up within the same period, as a high-tick count that does not equal twice the old compare value. A comparison off by one changes that count by one or two ticks in every period. It can also break the constant levels expected at compare values of zero and full scale.

// File: rtl/pc_pwm.sv
module pc_pwm #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic [2:0]   wave_mode,
  input  logic [W-1:0] cmp_a,
  input  logic [W-1:0] cmp_b,
  input  logic [1:0]   out_mode_a,
  input  logic [1:0]   out_mode_b,
  output logic [W-1:0] count,
  output logic         dir_down,
  output logic         pwm_a,
  output logic         pwm_b
);
  localparam logic [W-1:0] FULL     = '1;
  localparam logic [W-1:0] ONE      = W'(1);
  localparam logic [2:0]   MODE_FIX = 3'd1;
  localparam logic [2:0]   MODE_VAR = 3'd5;

  logic [W-1:0] buf_a, buf_b, top, cnt_n, buf_a_n, buf_b_n, top_n;
  logic         run, at_top, at_bot, load, dir_n;

  assign run    = (wave_mode == MODE_FIX) || (wave_mode == MODE_VAR);
  assign top    = (wave_mode == MODE_VAR) ? buf_a : FULL;
  assign at_top = !dir_down && (count >= top);
  assign at_bot = dir_down && (count == '0);
  assign load   = !run || (tick && at_top);

  assign buf_a_n = load ? cmp_a : buf_a;
  assign buf_b_n = load ? cmp_b : buf_b;
  assign top_n   = (wave_mode == MODE_VAR) ? buf_a_n : FULL;

  always_comb begin
    cnt_n = count;
    dir_n = dir_down;
    if (run && tick) begin
      if (top == '0) begin
        cnt_n = '0;
        dir_n = 1'b0;
      end else if (at_top) begin
        cnt_n = count - ONE;
        dir_n = 1'b1;
      end else if (at_bot) begin
        cnt_n = ONE;
        dir_n = 1'b0;
      end else begin
        cnt_n = dir_down ? count - ONE : count + ONE;
      end
    end
  end

  function automatic logic pin_level(input logic [W-1:0] c, input logic d,
                                     input logic [W-1:0] r, input logic [W-1:0] t,
                                     input logic [1:0] om);
    logic act;
    if (r == '0)      act = 1'b0;
    else if (r >= t)  act = 1'b1;
    else if (d)       act = (c <= r);
    else              act = (c < r);
    return om[1] & (act ^ om[0]);
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count    <= '0;
      dir_down <= 1'b0;
      buf_a    <= '0;
      buf_b    <= '0;
      pwm_a    <= 1'b0;
      pwm_b    <= 1'b0;
    end else begin
      count    <= cnt_n;
      dir_down <= dir_n;
      buf_a    <= buf_a_n;
      buf_b    <= buf_b_n;
      pwm_a    <= pin_level(cnt_n, dir_n, buf_a_n, top_n, out_mode_a);
      pwm_b    <= pin_level(cnt_n, dir_n, buf_b_n, top_n, out_mode_b);
    end
  end
endmodule

// File: rtl/pc_pwm_chk.sv
module pc_pwm_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         tick,
  input logic         run,
  input logic [W-1:0] top,
  input logic [W-1:0] count,
  input logic         dir_down,
  input logic [1:0]   out_mode_a,
  input logic [1:0]   out_mode_b,
  input logic         pwm_a,
  input logic         pwm_b
);
  a_r2_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> ($stable(count) && $stable(dir_down)));

  a_r1_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> ($stable(count) && $stable(dir_down)));

  a_r3_climb: assert property (@(posedge clk) disable iff (!rst_n)
    (run && tick && !dir_down && count < top) |=> (!dir_down && count == $past(count) + 1'b1));

  a_r3_turn_top: assert property (@(posedge clk) disable iff (!rst_n)
    (run && tick && !dir_down && count >= top && top != '0) |=> (dir_down && count == $past(count) - 1'b1));

  a_r4_turn_bottom: assert property (@(posedge clk) disable iff (!rst_n)
    (run && tick && dir_down && count == '0 && top != '0) |=> (!dir_down && count == W'(1)));

  a_r12_zero_top: assert property (@(posedge clk) disable iff (!rst_n)
    (run && tick && top == '0) |=> (count == '0 && !dir_down));

  a_r7_off_a: assert property (@(posedge clk) disable iff (!rst_n)
    !out_mode_a[1] |=> !pwm_a);

  a_r7_off_b: assert property (@(posedge clk) disable iff (!rst_n)
    !out_mode_b[1] |=> !pwm_b);
endmodule

bind pc_pwm pc_pwm_chk #(.W(W)) chk_i (
  .clk(clk), .rst_n(rst_n), .tick(tick), .run(run), .top(top),
  .count(count), .dir_down(dir_down), .out_mode_a(out_mode_a),
  .out_mode_b(out_mode_b), .pwm_a(pwm_a), .pwm_b(pwm_b)
);

// File: tb/pc_pwm_tb.sv
`timescale 1ns/1ps
module pc_pwm_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0;
  logic [2:0] wave_mode = 3'd0;
  logic [7:0] cmp_a = 8'd0, cmp_b = 8'd0;
  logic [1:0] out_mode_a = 2'b00, out_mode_b = 2'b00;
  logic [7:0] count;
  logic       dir_down, pwm_a, pwm_b;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #10 clk = ~clk;

  pc_pwm dut_i (
    .clk(clk), .rst_n(rst_n), .tick(tick), .wave_mode(wave_mode),
    .cmp_a(cmp_a), .cmp_b(cmp_b), .out_mode_a(out_mode_a), .out_mode_b(out_mode_b),
    .count(count), .dir_down(dir_down), .pwm_a(pwm_a), .pwm_b(pwm_b)
  );

  task automatic check(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Reference model built from the requirements
  logic [7:0] m_cnt, m_ba, m_bb;
  logic       m_dir, m_pa, m_pb;

  function automatic logic ref_pin(input logic [7:0] c, input logic d, input logic [7:0] r,
                                   input logic [7:0] t, input logic [1:0] om);
    logic hi;
    if (om[1] == 1'b0) return 1'b0;
    if (r == 8'd0)      hi = 1'b0;
    else if (r >= t)    hi = 1'b1;
    else                hi = d ? (c <= r) : (c < r);
    return om[0] ? !hi : hi;
  endfunction

  always @(posedge clk) begin : model
    logic [7:0] t, nc, nba, nbb, nt;
    logic nd, running, leave;
    if (!rst_n) begin
      m_cnt <= 8'd0; m_dir <= 1'b0; m_ba <= 8'd0; m_bb <= 8'd0;
      m_pa <= 1'b0;  m_pb <= 1'b0;
    end else begin
      running = (wave_mode == 3'd1) || (wave_mode == 3'd5);
      t  = (wave_mode == 3'd5) ? m_ba : 8'hFF;
      nc = m_cnt; nd = m_dir;
      leave = !m_dir && (m_cnt >= t);
      if (running && tick) begin
        if (t == 8'd0)               begin nc = 8'd0; nd = 1'b0; end
        else if (leave)              begin nc = m_cnt - 8'd1; nd = 1'b1; end
        else if (m_dir && m_cnt == 0) begin nc = 8'd1; nd = 1'b0; end
        else if (m_dir)              nc = m_cnt - 8'd1;
        else                         nc = m_cnt + 8'd1;
      end
      nba = (!running || (tick && leave)) ? cmp_a : m_ba;
      nbb = (!running || (tick && leave)) ? cmp_b : m_bb;
      nt  = (wave_mode == 3'd5) ? nba : 8'hFF;
      m_cnt <= nc; m_dir <= nd; m_ba <= nba; m_bb <= nbb;
      m_pa <= ref_pin(nc, nd, nba, nt, out_mode_a);
      m_pb <= ref_pin(nc, nd, nbb, nt, out_mode_b);
    end
  end

  // {mode[2:0], a[7:0], b[7:0], om_a[1:0], om_b[1:0], slow}
  localparam int NROWS = 8;
  localparam logic [23:0] ROWS [NROWS] = '{
    {3'd1, 8'd40,  8'd200, 2'b10, 2'b11, 1'b0},
    {3'd1, 8'd0,   8'd255, 2'b10, 2'b10, 1'b1},
    {3'd5, 8'd60,  8'd20,  2'b10, 2'b11, 1'b0},
    {3'd5, 8'd3,   8'd1,   2'b11, 2'b10, 1'b0},
    {3'd1, 8'd128, 8'd127, 2'b01, 2'b11, 1'b1},
    {3'd5, 8'd1,   8'd0,   2'b10, 2'b10, 1'b0},
    {3'd5, 8'd200, 8'd250, 2'b11, 2'b10, 1'b0},
    {3'd1, 8'd254, 8'd1,   2'b10, 2'b11, 1'b0}
  };

  task automatic set_cfg(input logic [2:0] m, input logic [7:0] a, input logic [7:0] b,
                         input logic [1:0] oa, input logic [1:0] ob);
    wave_mode = m; cmp_a = a; cmp_b = b; out_mode_a = oa; out_mode_b = ob;
  endtask

  // Waits for a rise of dir_down, then counts one period of samples
  task automatic measure(output int per, output int ha, output int hb,
                         input int chg_at, input logic [7:0] new_a);
    logic prev, rise;
    per = 0; ha = 0; hb = 0;
    @(negedge clk); prev = dir_down;
    do begin @(negedge clk); rise = dir_down && !prev; prev = dir_down; end while (!rise);
    do begin
      per++; ha += int'(pwm_a); hb += int'(pwm_b);
      if (per == chg_at) cmp_a = new_a;
      @(negedge clk); rise = dir_down && !prev; prev = dir_down;
    end while (!rise && per < 2000);
  endtask

  initial begin : watchdog
    #(200000 * 20);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog (all requirements) actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin : stim
    int per, ha, hb, n0, nt, mis_p, mis_d;
    logic [7:0] prevc, snap;
    logic snapd;

    repeat (3) @(negedge clk);
    check("R5 reset count", count, 0);
    check("R5 reset dir_down", dir_down, 0);
    check("R5 reset pwm_a", pwm_a, 0);
    check("R5 reset pwm_b", pwm_b, 0);
    rst_n = 1'b1;

    // Vector table against the model
    for (int r = 0; r < NROWS; r++) begin
      int mism;
      logic slow;
      mism = 0;
      set_cfg(ROWS[r][23:21], ROWS[r][20:13], ROWS[r][12:5], ROWS[r][4:3], ROWS[r][2:1]);
      slow = ROWS[r][0];
      for (int k = 0; k < 1100; k++) begin
        tick = slow ? k[0] : 1'b1;
        @(negedge clk);
        if (count !== m_cnt || dir_down !== m_dir || pwm_a !== m_pa || pwm_b !== m_pb) begin
          if (mism == 0)
            $display("FAIL R3/R8/R10/R11 row %0d actual=%0d/%0b/%0b/%0b expected=%0d/%0b/%0b/%0b",
                     r, count, dir_down, pwm_a, pwm_b, m_cnt, m_dir, m_pa, m_pb);
          mism++;
        end
      end
      total++;
      if (mism != 0) bad++;
    end

    // R2: no tick, no motion
    set_cfg(3'd1, 8'd40, 8'd100, 2'b10, 2'b11);
    tick = 1'b1;
    repeat (37) @(negedge clk);
    tick = 1'b0;
    @(negedge clk); snap = count; snapd = dir_down;
    repeat (20) @(negedge clk);
    check("R2 count held without tick", count, snap);
    check("R2 dir held without tick", dir_down, snapd);
    tick = 1'b1;

    // R1: frozen mode
    wave_mode = 3'd3;
    @(negedge clk); snap = count;
    repeat (20) @(negedge clk);
    check("R1 frozen mode holds count", count, snap);

    // R4 / R8 / R10: full-scale period
    set_cfg(3'd1, 8'd40, 8'd100, 2'b10, 2'b11);
    measure(per, ha, hb, 0, 8'd0);
    check("R4 period 2x255", per, 510);
    check("R8 high ticks 2x40", ha, 80);
    check("R10 inverted high ticks", hb, 510 - 200);

    // R3 / R4 / R5 / R11: sample one period right after a turn
    n0 = 0; nt = 0; mis_p = 0; mis_d = 0; prevc = count;
    for (int k = 0; k < 510; k++) begin
      @(negedge clk);
      if (count == 8'd255) nt++;
      if (count == 8'd0) n0++;
      if (dir_down != (count < prevc)) mis_d++;
      if (pwm_a != (dir_down ? (count <= 8'd40) : (count < 8'd40))) mis_p++;
      prevc = count;
    end
    check("R3 turning value shown once", nt, 1);
    check("R4 zero shown once", n0, 1);
    check("R5 dir_down matches step direction", mis_d, 0);
    check("R11 pin aligned with count", mis_p, 0);

    // R9: extremes
    set_cfg(3'd1, 8'd0, 8'd255, 2'b10, 2'b10);
    measure(per, ha, hb, 0, 8'd0);
    check("R9 compare 0 never high", ha, 0);
    check("R9 compare 255 always high", hb, 510);

    // R1 / R9: mode 5 turning at channel A
    set_cfg(3'd5, 8'd100, 8'd30, 2'b10, 2'b10);
    measure(per, ha, hb, 0, 8'd0);
    check("R1 mode 5 period 2x100", per, 200);
    check("R9 channel A at turning value stays high", ha, 200);
    check("R8 channel B high ticks 2x30", hb, 60);

    // R12: turning value of zero
    cmp_a = 8'd0;
    repeat (300) @(negedge clk);
    mis_p = 0;
    for (int k = 0; k < 30; k++) begin
      @(negedge clk);
      if (count != 8'd0 || dir_down) mis_p++;
    end
    check("R12 zero turning value holds count at 0", mis_p, 0);

    // R6: mid-period change does not split the period
    set_cfg(3'd1, 8'd40, 8'd10, 2'b10, 2'b10);
    measure(per, ha, hb, 0, 8'd0);
    measure(per, ha, hb, 100, 8'd200);
    check("R6 period keeps old compare", ha, 80);
    measure(per, ha, hb, 0, 8'd0);
    check("R6 new compare after turn", ha, 400);

    // R7: disconnected codes
    set_cfg(3'd1, 8'd40, 8'd40, 2'b00, 2'b01);
    measure(per, ha, hb, 0, 8'd0);
    check("R7 code 00 holds pin low", ha, 0);
    check("R7 code 01 holds pin low", hb, 0);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule